// File: doc/BRIEF.md
# One-Wire Bus Master

This block is a bus master for a single-wire, open-drain serial line. Software reaches it through a byte-wide register interface with three registers: control, time divider and soft reset. A prescaler driven by the divider register turns the system clock into a microsecond tick. All bus timing is counted in these ticks.

Software starts one bus operation at a time by setting a command bit in the control register. There are three operations: a reset pulse with presence detection, a write-0 slot, and a write-1 slot that also reads a bit. The command bit stays set while the operation runs and clears itself when the operation ends. Once it has cleared, the result flags in the same register can be read. The block only ever pulls the line low, through an output enable. The returning line level passes through a two-flop synchronizer before it is sampled.

Top module: `owire_master`

## Requirements
- R1: After reset, the control, divider and soft-reset registers all read 0x00 and `bus_oe` is low.
- R2: The register map is as follows. Address 0 is control, address 2 is the divider (read/write, 8 bits) and address 4 is soft reset (bit 0 read/write). Any other address reads 0x00.
- R3: Writing control bit 7 while idle starts a reset sequence. The line is pulled low for 511 µs. The sequence takes 1023 µs in total, and then bit 7 reads 0 again.
- R4: Control bit 6 (presence) is set to 1 if the synchronized line is low at 581 µs into a reset sequence, which is 70 µs after the line is released. Otherwise bit 6 is set to 0.
- R5: Writing control bit 5 while idle starts a write-0 slot. The line is pulled low for 60 µs, the slot takes 61 µs in total, and then bit 5 reads 0.
- R6: Writing control bit 4 while idle starts a write-1/read slot. The line is pulled low for 5 µs. The synchronized line is sampled at 15 µs into control bit 3 (1 means high). The slot takes 61 µs, and then bit 4 reads 0.
- R7: With divider value D, one microsecond tick lasts D+1 clock cycles, so every duration above scales by D+1.
- R8: A control write made while an operation is running is ignored. The running operation keeps its length and no further operation follows it.
- R9: If several command bits are written at once, bit 7 has priority over bit 5, and bit 5 has priority over bit 4.
- R10: While soft-reset bit 0 is 1, any running operation is aborted and the line is released. Presence, the read bit and the divider are cleared, and control writes are ignored. Writing 0 releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| bus_oe | output | 1 | Pull the line low when 1 |
| bus_in | input | 1 | Line level returned from the pad |

## Verification
Each operation runs with the divider at 0 and at a non-zero value. The bench compares the length of the busy period and the count of cycles with the line pulled low, which separates the three slot shapes and checks the prescaler scaling. The slave model pulls the line low either for the whole operation or in short windows placed just before or just around the sampling instant. This shows that presence and the read bit are taken at the intended microsecond, not merely anywhere in the slot. Further runs write commands during an operation, set several command bits at once, and assert soft reset in the middle of a sequence.

// File: rtl/owire_master.sv
module owire_master #(
  parameter int RST_LOW_US = 511,
  parameter int RST_REC_US = 512,
  parameter int PRES_AT_US = 70,
  parameter int SLOT_US    = 60,
  parameter int RD_LOW_US  = 5,
  parameter int RD_AT_US   = 15,
  parameter int REC_US     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_oe,
  input  logic       bus_in
);

  localparam int RST_END_I = RST_LOW_US + RST_REC_US - 1;
  localparam int SLOT_END_I = SLOT_US + REC_US - 1;
  localparam int US_W = $clog2(RST_END_I + 1);
  localparam logic [US_W-1:0] RST_END  = US_W'(RST_END_I);
  localparam logic [US_W-1:0] SLOT_END = US_W'(SLOT_END_I);
  localparam logic [US_W-1:0] PRES_AT  = US_W'(RST_LOW_US + PRES_AT_US);
  localparam logic [US_W-1:0] RD_AT    = US_W'(RD_AT_US);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd2;
  localparam logic [2:0] A_SRST = 3'd4;

  typedef enum logic [1:0] {OP_IDLE, OP_RST, OP_W0, OP_W1} op_e;

  op_e             op, new_op;
  logic [US_W-1:0] us_cnt, end_us, low_us;
  logic [7:0]      pre_cnt, div_q;
  logic [1:0]      sync;
  logic            srst_q, presence, rbit;

  wire idle     = (op == OP_IDLE);
  wire tick     = (pre_cnt >= div_q);
  wire wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  wire wr_div   = reg_we && (reg_addr == A_DIV);
  wire wr_srst  = reg_we && (reg_addr == A_SRST);
  wire clear    = srst_q || (wr_srst && reg_wdata[0]);
  wire start_op = wr_ctrl && idle && !clear;
  wire last     = !idle && tick && (us_cnt == end_us);
  wire do_pres  = (op == OP_RST) && tick && (us_cnt == PRES_AT);
  wire do_rd    = (op == OP_W1) && tick && (us_cnt == RD_AT);

  always_comb begin
    if (reg_wdata[7])      new_op = OP_RST;
    else if (reg_wdata[5]) new_op = OP_W0;
    else if (reg_wdata[4]) new_op = OP_W1;
    else                   new_op = OP_IDLE;
  end

  assign end_us = (op == OP_RST) ? RST_END : SLOT_END;

  always_comb begin
    case (op)
      OP_RST:  low_us = US_W'(RST_LOW_US);
      OP_W0:   low_us = US_W'(SLOT_US);
      OP_W1:   low_us = US_W'(RD_LOW_US);
      default: low_us = '0;
    endcase
  end

  assign bus_oe = !idle && (us_cnt < low_us);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {op == OP_RST, presence, op == OP_W0, op == OP_W1, rbit, 3'b000};
      A_DIV:   reg_rdata = div_q;
      A_SRST:  reg_rdata = {7'd0, srst_q};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op       <= OP_IDLE;
      us_cnt   <= '0;
      pre_cnt  <= '0;
      div_q    <= '0;
      sync     <= 2'b11;
      srst_q   <= 1'b0;
      presence <= 1'b0;
      rbit     <= 1'b0;
    end else begin
      sync <= {sync[0], bus_in};
      if (wr_srst) srst_q <= reg_wdata[0];
      if (clear) begin
        op       <= OP_IDLE;
        us_cnt   <= '0;
        pre_cnt  <= '0;
        div_q    <= '0;
        presence <= 1'b0;
        rbit     <= 1'b0;
      end else begin
        if (wr_div) div_q <= reg_wdata;
        if (start_op) begin
          op      <= new_op;
          us_cnt  <= '0;
          pre_cnt <= '0;
        end else if (!idle) begin
          pre_cnt <= tick ? '0 : pre_cnt + 8'd1;
          if (tick) begin
            if (last) begin
              op     <= OP_IDLE;
              us_cnt <= '0;
            end else begin
              us_cnt <= us_cnt + 1'b1;
            end
          end
        end
        if (do_pres) presence <= !sync[1];
        if (do_rd)   rbit     <= sync[1];
      end
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !last && !clear) |=> $stable(op));

  // R3
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_op && reg_wdata[7]) |=> (op == OP_RST && bus_oe));

  // R10
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (idle && !bus_oe && !presence && !rbit));

  // R4
  pres_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pres |-> !bus_oe);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |-> !bus_oe);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (us_cnt <= end_us));

endmodule

// File: tb/owire_master_tb.sv
module owire_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       bus_oe;
  logic       bus_in;
  logic       slave_low = 1'b0;

  always #2 clk = ~clk;
  assign bus_in = ~(bus_oe | slave_low);

  owire_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  typedef struct {
    int    dur;
    int    oe;
    int    kind;
    int    res;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   done_cnt = 0;
  bit   mon_en = 1'b1;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
    reg_addr = 3'd0;
  endtask

  // kind: 1 reset/presence, 2 write-0, 3 write-1/read
  task automatic push_exp(int kind, int div, int res, string tag);
    exp_t e;
    e.kind = kind; e.res = res; e.tag = tag;
    e.dur = (kind == 1 ? 1023 : 61) * (div + 1);
    e.oe  = (kind == 1 ? 511 : (kind == 2 ? 60 : 5)) * (div + 1);
    exp_q.push_back(e);
  endtask

  task automatic wait_done(int target);
    while (done_cnt < target) @(posedge clk);
  endtask

  task automatic run_op(logic [7:0] cmd, int kind, int div, int res, string tag);
    int t;
    t = done_cnt + 1;
    push_exp(kind, div, res, tag);
    wr(3'd0, cmd);
    wait_done(t);
  endtask

  initial begin : monitor
    int  dur = 0;
    int  oen = 0;
    bit  in_op = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (reg_addr == 3'd0 && (reg_rdata[7] | reg_rdata[5] | reg_rdata[4])) begin
        dur++;
        if (bus_oe) oen++;
        in_op = 1'b1;
      end else if (in_op) begin
        in_op = 1'b0;
        if (mon_en) begin
          if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8 unexpected operation actual=%0d expected=0", dur);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " duration"}, dur, e.dur);
            check({e.tag, " low time"}, oen, e.oe);
            if (e.kind == 1) check({e.tag, " presence"}, int'(reg_rdata[6]), e.res);
            if (e.kind == 3) check({e.tag, " read bit"}, int'(reg_rdata[3]), e.res);
          end
          done_cnt++;
        end
        dur = 0; oen = 0;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin : driver
    int v;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 control", v, 0);
    rd(3'd2, v); check("R1 divider", v, 0);
    rd(3'd4, v); check("R1 soft reset", v, 0);
    check("R1 bus_oe", int'(bus_oe), 0);

    // R2 map
    wr(3'd2, 8'h5A); rd(3'd2, v); check("R2 divider readback", v, 8'h5A);
    rd(3'd1, v); check("R2 unmapped addr", v, 0);
    rd(3'd6, v); check("R2 unmapped addr 6", v, 0);
    wr(3'd2, 8'h00);

    // R3 R4 presence from slave held low throughout
    slave_low = 1'b1;
    run_op(8'h80, 1, 0, 1, "R3 R4 reset slave low");
    slave_low = 1'b0;
    run_op(8'h80, 1, 0, 0, "R3 R4 reset no slave");

    // R4 pulse around the 70us sample point
    t = done_cnt + 1;
    push_exp(1, 0, 1, "R4 late presence pulse");
    wr(3'd0, 8'h80);
    repeat (571) @(negedge clk);
    slave_low = 1'b1;
    repeat (40) @(negedge clk);
    slave_low = 1'b0;
    wait_done(t);

    // R4 pulse ending before the sample point
    t = done_cnt + 1;
    push_exp(1, 0, 0, "R4 early pulse");
    wr(3'd0, 8'h80);
    repeat (541) @(negedge clk);
    slave_low = 1'b1;
    repeat (20) @(negedge clk);
    slave_low = 1'b0;
    wait_done(t);

    // R5 write-0
    run_op(8'h20, 2, 0, 0, "R5 write0");

    // R6 read slot
    run_op(8'h10, 3, 0, 1, "R6 read high");
    slave_low = 1'b1;
    run_op(8'h10, 3, 0, 0, "R6 read low");
    slave_low = 1'b0;
    t = done_cnt + 1;
    push_exp(3, 0, 1, "R6 pulse before sample");
    wr(3'd0, 8'h10);
    slave_low = 1'b1;
    repeat (8) @(negedge clk);
    slave_low = 1'b0;
    wait_done(t);
    t = done_cnt + 1;
    push_exp(3, 0, 0, "R6 pulse at sample");
    wr(3'd0, 8'h10);
    repeat (11) @(negedge clk);
    slave_low = 1'b1;
    repeat (8) @(negedge clk);
    slave_low = 1'b0;
    wait_done(t);

    // R7 divider scaling
    wr(3'd2, 8'd2);
    run_op(8'h10, 3, 2, 1, "R7 read div2");
    run_op(8'h20, 2, 2, 0, "R7 write0 div2");
    wr(3'd2, 8'd1);
    slave_low = 1'b1;
    run_op(8'h80, 1, 1, 1, "R7 reset div1");
    slave_low = 1'b0;
    wr(3'd2, 8'd0);

    // R8 write during a running operation is ignored
    t = done_cnt + 1;
    push_exp(1, 0, 0, "R8 busy reset");
    wr(3'd0, 8'h80);
    repeat (100) @(negedge clk);
    wr(3'd0, 8'h20);
    rd(3'd0, v); check("R8 write0 bit stays clear", v & 8'hB0, 8'h80);
    wait_done(t);
    repeat (20) @(negedge clk);
    check("R8 no follow-on op", int'(bus_oe), 0);
    rd(3'd0, v); check("R8 idle after", v & 8'hB0, 0);

    // R9 priority
    run_op(8'hB0, 1, 0, 0, "R9 bits 7,5,4");
    run_op(8'h30, 2, 0, 0, "R9 bits 5,4");

    // R10 soft reset
    slave_low = 1'b1;
    run_op(8'h80, 1, 0, 1, "R10 presence set first");
    slave_low = 1'b0;
    wr(3'd2, 8'd3);
    mon_en = 1'b0;
    wr(3'd0, 8'h80);
    repeat (100) @(negedge clk);
    wr(3'd4, 8'h01);
    check("R10 line released", int'(bus_oe), 0);
    rd(3'd0, v); check("R10 control cleared", v, 0);
    rd(3'd2, v); check("R10 divider cleared", v, 0);
    rd(3'd4, v); check("R10 bit readback", v, 1);
    wr(3'd0, 8'h20);
    repeat (5) @(negedge clk);
    rd(3'd0, v); check("R10 command ignored while held", v, 0);
    check("R10 no drive while held", int'(bus_oe), 0);
    wr(3'd4, 8'h00);
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    run_op(8'h10, 3, 0, 1, "R10 works after release");

    repeat (10) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    finish_up();
  end
endmodule